// File: doc/BRIEF.md
# Serial Register Port

This block is a slave serial port that gives a host read and write access to a small bank of byte-wide registers. It runs entirely on the host's serial clock, which it samples on the rising edge, and listens only while the active-low select is held low. Every transaction opens with an 8-bit command. The command carries a direction flag and a 5-bit register address. A data phase follows, and its length in bytes is fixed by the address.

Two bits of the control register at address 0 set the port's own behaviour. Bit 15 picks the shift order: 0 shifts the most significant bit first and 1 shifts the least significant bit first. Bit 7 picks where read data leaves the block: 0 sends it back on the shared data line and 1 sends it on a dedicated output line. A host that deasserts select in the middle of a transaction only pauses it. A separate port-reset input cancels the transaction and leaves the registers unchanged.

The sequencer has three states. `ST_INSTR` collects the command. `ST_WDATA` collects write data. `ST_RDATA` shifts out read data. The transitions are:
- `ST_INSTR` to `ST_WDATA` on the eighth command bit when the flag is 0.
- `ST_INSTR` to `ST_RDATA` on the eighth command bit when the flag is 1.
- `ST_WDATA` to `ST_INSTR` on the last data bit, which also writes the register.
- `ST_RDATA` to `ST_INSTR` on the last data bit.
- Any state to `ST_INSTR` on port reset or chip reset.
- Every state holds its place for as long as select is high.

Top module: `serial_regport`

## Requirements
- R1: The command byte always comes before the data phase. Its bit 7 is the direction, where 1 means read and 0 means write. Bits 6 and 5 have no effect. Bits 4..0 give the register address.
- R2: A mapped address a (0 to 4) has 4 - (a mod 4) data bytes, so addresses 0 to 4 have 4, 3, 2, 1 and 4 bytes. Every unmapped address has 1 byte. When that many bytes have been shifted, the next bit begins a new command.
- R3: Write data reaches the register in one step, on the rising edge that samples the last data bit. A write that is cut short leaves the register at its old value. Bits above the register's byte length are stored as 0.
- R4: A read shifts out the addressed register's current contents. Reads of unmapped addresses return zeros. Writes to unmapped addresses change no register. The data outputs are enabled only during a read data phase.
- R5: While select is high, both output enables are low. The transaction pauses and resumes at the same bit position once select returns low.
- R6: A high level on port_rst cancels the current transaction at once and returns the port to waiting for a command. Register contents are kept.
- R7: When control bit 7 is 0, read data is driven on sdio_o and sdo_oe stays low. When it is 1, read data is driven on sdo_o and sdio_oe stays low.
- R8: When control bit 15 is 0, the command and the data are shifted MSB first, starting with bit 8·n−1 of an n-byte register. When it is 1, they are shifted LSB first, starting with bit 0. Input bits are sampled on the rising clock edge. Each read bit is valid from the rising edge before the edge that would sample it.
- R9: A new value of control bit 7 or bit 15 takes effect from the start of the next transaction. The transaction that writes it runs to the end under the old setting.
- R10: A low level on rst_n clears every register to 0, which selects MSB first and the shared data line, and idles the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous chip reset, active low; clears registers |
| port_rst | input | 1 | Asynchronous transaction abort, active high; keeps registers |
| sel_n | input | 1 | Active-low select; high pauses the transaction |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Read data on the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo_o | output | 1 | Read data on the dedicated output line |
| sdo_oe | output | 1 | Drive enable for the dedicated output line |

## Verification
Two events can fall on the same clock edge: the write of a new control value and the capture of the port mode for the next transaction. The last data bit of a control write and the first command bit of the following transaction are one edge apart, so the new mode must be picked up there with no stale copy in between. The bench runs its command sequences back to back with select held low, so every control write is followed at once by a read. The scoreboard then expects the read bits in the new order and on the new pin. The control write itself must still be decoded in the old order, which the scoreboard checks in the same sequence. A pause inside a read that is already in the new mode also checks that the latched mode survives deselection.

// File: rtl/srp_pkg.sv
`timescale 1ns/1ps
package srp_pkg;

    typedef enum logic [1:0] {
        ST_INSTR = 2'd0,
        ST_WDATA = 2'd1,
        ST_RDATA = 2'd2
    } srp_state_e;

    // Byte length of an address: mapped slots cycle through maxb..1, unmapped take one byte
    function automatic int unsigned reg_bytes(input int unsigned addr,
                                              input int unsigned nregs,
                                              input int unsigned maxb);
        if (addr < nregs)
            return maxb - (addr % maxb);
        return 1;
    endfunction

endpackage

// File: rtl/srp_fsm.sv
`timescale 1ns/1ps
module srp_fsm
    import srp_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MAX_BYTES = 4,
    parameter int NUM_REGS  = 5,
    localparam int DW       = 8 * MAX_BYTES,
    localparam int CNT_W    = $clog2(DW)
) (
    input  logic              sclk,
    input  logic              abort_n,
    input  logic              sel_n,
    input  logic              din,
    input  logic              lsb_first,
    output srp_state_e        state,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  pos,
    output logic              wr_en,
    output logic [DW-1:0]     wr_word
);

    srp_state_e        state_n;
    logic [CNT_W-1:0]  cnt_n;
    logic [ADDR_W-1:0] addr_n;
    logic [7:0]        ibuf, ibuf_n, ibuf_nx;
    logic [DW-1:0]     wbuf, wbuf_n;
    logic [CNT_W:0]    nbits;
    logic              last_bit;
    logic              active;

    assign active = !sel_n;

    // Length of the current phase in bits
    always_comb begin
        if (state == ST_INSTR)
            nbits = (CNT_W+1)'(8);
        else
            nbits = (CNT_W+1)'(8 * reg_bytes(32'(addr), NUM_REGS, MAX_BYTES));
    end

    assign last_bit = ({1'b0, cnt} == nbits - 1'b1);
    assign pos      = lsb_first ? cnt : CNT_W'(nbits - {1'b0, cnt} - 1'b1);

    always_comb begin
        ibuf_nx           = ibuf;
        ibuf_nx[pos[2:0]] = din;
        wr_word           = wbuf;
        wr_word[pos]      = din;
    end

    assign wr_en = active && (state == ST_WDATA) && last_bit;

    // Next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        addr_n  = addr;
        ibuf_n  = ibuf;
        wbuf_n  = wbuf;
        if (active) begin
            unique case (state)
                ST_INSTR: begin
                    ibuf_n = ibuf_nx;
                    if (last_bit) begin
                        addr_n  = ibuf_nx[ADDR_W-1:0];
                        state_n = ibuf_nx[7] ? ST_RDATA : ST_WDATA;
                        cnt_n   = '0;
                        wbuf_n  = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_WDATA: begin
                    wbuf_n = wr_word;
                    if (last_bit) begin
                        state_n = ST_INSTR;
                        cnt_n   = '0;
                        ibuf_n  = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (last_bit) begin
                        state_n = ST_INSTR;
                        cnt_n   = '0;
                        ibuf_n  = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: begin
                    state_n = ST_INSTR;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge sclk or negedge abort_n) begin
        if (!abort_n) begin
            state <= ST_INSTR;
            cnt   <= '0;
            addr  <= '0;
            ibuf  <= '0;
            wbuf  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            addr  <= addr_n;
            ibuf  <= ibuf_n;
            wbuf  <= wbuf_n;
        end
    end

endmodule

// File: rtl/srp_regfile.sv
`timescale 1ns/1ps
module srp_regfile
    import srp_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MAX_BYTES = 4,
    parameter int NUM_REGS  = 5,
    parameter int CTRL_ADDR = 0,
    parameter int ORDER_BIT = 15,
    parameter int PIN_BIT   = 7,
    localparam int DW       = 8 * MAX_BYTES
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_word,
    output logic              ctrl_lsb,
    output logic              ctrl_4w
);

    logic [DW-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam int NB = int'(reg_bytes(g, NUM_REGS, MAX_BYTES));
        localparam logic [DW-1:0] MASK = {DW{1'b1}} >> (DW - 8 * NB);
        logic [DW-1:0] q;
        always_ff @(posedge sclk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                q <= wr_word & MASK;
        end
        assign regs[g] = q;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i))
                rd_word = regs[i];
        end
    end

    assign ctrl_lsb = regs[CTRL_ADDR][ORDER_BIT];
    assign ctrl_4w  = regs[CTRL_ADDR][PIN_BIT];

endmodule

// File: rtl/srp_pinmux.sv
`timescale 1ns/1ps
module srp_pinmux
    import srp_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    localparam int DW       = 8 * MAX_BYTES,
    localparam int CNT_W    = $clog2(DW)
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  srp_state_e       state,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] pos,
    input  logic [DW-1:0]    rd_word,
    input  logic             ctrl_lsb,
    input  logic             ctrl_4w,
    output logic             lsb_first,
    output logic             sdio_o,
    output logic             sdio_oe,
    output logic             sdo_o,
    output logic             sdo_oe
);

    logic at_start;
    logic lsb_q, w4_q, four_wire;

    assign at_start  = (state == ST_INSTR) && (cnt == '0);
    assign lsb_first = at_start ? ctrl_lsb : lsb_q;
    assign four_wire = at_start ? ctrl_4w  : w4_q;

    // Mode is captured with the first command bit and held for the transaction
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            lsb_q <= 1'b0;
            w4_q  <= 1'b0;
        end else if (!sel_n && at_start) begin
            lsb_q <= ctrl_lsb;
            w4_q  <= ctrl_4w;
        end
    end

    // Output process
    always_comb begin
        logic drive, bit_v;
        drive   = !sel_n && (state == ST_RDATA);
        bit_v   = rd_word[pos];
        sdio_oe = drive && !four_wire;
        sdo_oe  = drive && four_wire;
        sdio_o  = sdio_oe && bit_v;
        sdo_o   = sdo_oe && bit_v;
    end

endmodule

// File: rtl/serial_regport.sv
`timescale 1ns/1ps
module serial_regport
    import srp_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MAX_BYTES = 4,
    parameter int NUM_REGS  = 5,
    parameter int CTRL_ADDR = 0,
    parameter int ORDER_BIT = 15,
    parameter int PIN_BIT   = 7,
    localparam int DW       = 8 * MAX_BYTES,
    localparam int CNT_W    = $clog2(DW)
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic port_rst,
    input  logic sel_n,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe,
    output logic sdo_o,
    output logic sdo_oe
);

    logic              abort_n;
    srp_state_e        fsm_state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  bit_pos;
    logic [ADDR_W-1:0] cur_addr;
    logic              wr_en;
    logic [DW-1:0]     wr_word;
    logic [DW-1:0]     rd_word;
    logic              ctrl_lsb, ctrl_4w, lsb_first;

    assign abort_n = rst_n & ~port_rst;

    srp_fsm #(
        .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .NUM_REGS(NUM_REGS)
    ) u_fsm (
        .sclk(sclk), .abort_n(abort_n), .sel_n(sel_n), .din(sdio_i),
        .lsb_first(lsb_first), .state(fsm_state), .cnt(bit_cnt),
        .addr(cur_addr), .pos(bit_pos), .wr_en(wr_en), .wr_word(wr_word)
    );

    srp_regfile #(
        .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .NUM_REGS(NUM_REGS),
        .CTRL_ADDR(CTRL_ADDR), .ORDER_BIT(ORDER_BIT), .PIN_BIT(PIN_BIT)
    ) u_regs (
        .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(cur_addr),
        .wr_word(wr_word), .rd_addr(cur_addr), .rd_word(rd_word),
        .ctrl_lsb(ctrl_lsb), .ctrl_4w(ctrl_4w)
    );

    srp_pinmux #(
        .MAX_BYTES(MAX_BYTES)
    ) u_pins (
        .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n), .state(fsm_state),
        .cnt(bit_cnt), .pos(bit_pos), .rd_word(rd_word),
        .ctrl_lsb(ctrl_lsb), .ctrl_4w(ctrl_4w), .lsb_first(lsb_first),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
    );

endmodule

// File: rtl/srp_checker.sv
`timescale 1ns/1ps
module srp_checker
    import srp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             sclk,
    input logic             rst_n,
    input logic             port_rst,
    input logic             sel_n,
    input logic             sdio_oe,
    input logic             sdo_oe,
    input srp_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic             wr_en
);

    assert_hiz_deselect_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        sel_n |-> (!sdio_oe && !sdo_oe));

    assert_hold_paused_R5: assert property (@(posedge sclk) disable iff (!rst_n || port_rst)
        sel_n |=> ($stable(state) && $stable(cnt)));

    assert_single_pin_R7: assert property (@(posedge sclk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));

    assert_drive_in_read_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        (sdio_oe || sdo_oe) |-> (state == ST_RDATA));

    assert_commit_ends_R3: assert property (@(posedge sclk) disable iff (!rst_n || port_rst)
        wr_en |=> (state == ST_INSTR && cnt == '0));

    assert_abort_idle_R6: assert property (@(posedge sclk) disable iff (!rst_n)
        port_rst |-> (state == ST_INSTR && cnt == '0));

endmodule

bind serial_regport srp_checker #(.CNT_W(CNT_W)) u_chk (
    .sclk(sclk), .rst_n(rst_n), .port_rst(port_rst), .sel_n(sel_n),
    .sdio_oe(sdio_oe), .sdo_oe(sdo_oe), .state(fsm_state),
    .cnt(bit_cnt), .wr_en(wr_en)
);

// File: tb/serial_regport_test.sv
`timescale 1ns/1ps
module serial_regport_test;

    localparam int NREG = 5;
    localparam int MAXB = 4;

    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic port_rst = 1'b0;
    logic sel_n = 1'b1;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe;

    always #2.5 sclk = ~sclk;

    serial_regport uut (
        .sclk(sclk), .rst_n(rst_n), .port_rst(port_rst), .sel_n(sel_n),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe)
    );

    typedef struct {
        logic  val;
        logic  on_sdo;
        string req;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] mdl [NREG];

    function automatic void chk(input bit ok, input string req, input string what,
                                input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endfunction

    function automatic int nbytes(input int a);
        return (a < NREG) ? MAXB - (a % MAXB) : 1;
    endfunction

    // Monitor: compare every driven read bit against the scoreboard
    always @(negedge sclk) begin
        exp_t e;
        logic got;
        #1;
        if (sdio_oe || sdo_oe) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected drive", {30'd0, sdo_oe, sdio_oe}, 32'd0);
            end else begin
                e   = exp_q.pop_front();
                got = e.on_sdo ? sdo_o : sdio_o;
                chk(sdo_oe == e.on_sdo && sdio_oe == !e.on_sdo, "R7",
                    "pin select", {30'd0, sdo_oe, sdio_oe}, {30'd0, e.on_sdo, !e.on_sdo});
                chk(got == e.val, e.req, "read bit", {31'd0, got}, {31'd0, e.val});
            end
        end
    end

    task automatic put_bit(input logic b);
        @(negedge sclk);
        sel_n  = 1'b0;
        sdio_i = b;
    endtask

    task automatic pause(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge sclk);
            sel_n  = 1'b1;
            sdio_i = ~sdio_i;
            #1;
            chk(!sdio_oe && !sdo_oe, "R5", "enables while deselected",
                {30'd0, sdo_oe, sdio_oe}, 32'd0);
        end
    endtask

    // Driver: one transaction; read bits are pushed to the scoreboard
    task automatic xfer(input bit rd, input int addr, input logic [31:0] wv,
                        input logic [1:0] dc, input string req,
                        input int pause_at, input int abort_at);
        int          nb    = nbytes(addr);
        int          nbits = 8 * nb;
        logic [7:0]  ins   = {rd, dc, addr[4:0]};
        bit          lsb   = mdl[0][15];
        bit          w4    = mdl[0][7];
        logic [31:0] rv    = (addr < NREG) ? mdl[addr] : 32'd0;
        int          idx   = 0;
        for (int i = 0; i < 8; i++) begin
            if (idx == pause_at) pause(3);
            put_bit(ins[lsb ? i : 7 - i]);
            idx++;
        end
        for (int i = 0; i < nbits; i++) begin
            int p = lsb ? i : nbits - 1 - i;
            if (idx == pause_at) pause(3);
            if (idx == abort_at) begin
                @(negedge sclk);
                port_rst = 1'b1;
                sel_n    = 1'b1;
                @(negedge sclk);
                port_rst = 1'b0;
                return;
            end
            if (rd) begin
                exp_q.push_back('{rv[p], w4, req});
                put_bit(1'b0);
            end else begin
                put_bit(wv[p]);
            end
            idx++;
        end
        if (!rd && addr < NREG)
            mdl[addr] = wv & ((nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 32'd1));
    endtask

    task automatic rd_reg(input int addr, input string req);
        xfer(1'b1, addr, 32'd0, 2'b00, req, -1, -1);
    endtask

    task automatic wr_reg(input int addr, input logic [31:0] v, input string req);
        xfer(1'b0, addr, v, 2'b00, req, -1, -1);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge sclk);
            sel_n = 1'b1;
        end
    endtask

    initial begin
        #1000000;
        chk(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = 32'd0;
        repeat (3) @(negedge sclk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk(!sdio_oe && !sdo_oe, "R10", "enables after reset", {30'd0, sdo_oe, sdio_oe}, 32'd0);
        rd_reg(0, "R10");
        rd_reg(4, "R10");

        // R1/R2/R4/R8: write and read back, MSB first, back to back
        wr_reg(1, 32'h00A5_C3E1, "R4");
        rd_reg(1, "R8");
        wr_reg(2, 32'h0000_1234, "R2");
        rd_reg(2, "R2");
        // R3: upper bits beyond byte length dropped
        wr_reg(3, 32'hFFFF_FF5A, "R3");
        rd_reg(3, "R3");
        // R1: bits 6 and 5 are ignored
        xfer(1'b0, 3, 32'h0000_00C6, 2'b11, "R1", -1, -1);
        xfer(1'b1, 3, 32'd0, 2'b10, "R1", -1, -1);
        // R4: unmapped write ignored, unmapped read zero, R2: one byte then new command
        xfer(1'b0, 9, 32'h0000_00FF, 2'b00, "R4", -1, -1);
        rd_reg(9, "R4");
        rd_reg(20, "R2");
        rd_reg(1, "R4");
        rd_reg(2, "R4");
        idle(2);

        // R3/R6: aborted write keeps the old value
        wr_reg(4, 32'h1122_3344, "R3");
        xfer(1'b0, 4, 32'h9988_7766, 2'b00, "R6", 20, 20);
        rd_reg(4, "R6");
        xfer(1'b1, 1, 32'd0, 2'b00, "R6", -1, 12);
        rd_reg(1, "R6");

        // R5: pause inside a command and inside a data phase
        xfer(1'b0, 4, 32'hDEAD_BEEF, 2'b00, "R5", 5, -1);
        xfer(1'b1, 4, 32'd0, 2'b00, "R5", 20, -1);

        // R7/R9: switch to dedicated output pin
        wr_reg(0, 32'h0000_0080, "R9");
        rd_reg(1, "R7");
        // R8/R9: LSB first plus dedicated pin; control write itself in MSB order
        wr_reg(0, 32'h0000_8080, "R9");
        xfer(1'b1, 2, 32'd0, 2'b00, "R8", 14, -1);
        wr_reg(3, 32'h0000_0093, "R8");
        rd_reg(3, "R8");
        // LSB first on shared line, written in LSB order
        wr_reg(0, 32'h0000_8000, "R9");
        rd_reg(4, "R7");
        rd_reg(0, "R9");
        // back to MSB first, written in LSB order
        wr_reg(0, 32'h0000_0000, "R9");
        rd_reg(1, "R9");
        idle(3);

        // R10: chip reset clears registers
        wr_reg(1, 32'h0077_6655, "R10");
        @(negedge sclk);
        rst_n = 1'b0;
        sel_n = 1'b1;
        @(negedge sclk);
        rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) mdl[i] = 32'd0;
        rd_reg(1, "R10");
        rd_reg(0, "R10");
        idle(4);

        chk(exp_q.size() == 0, "R2", "pending read bits", exp_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule